// File: doc/BRIEF.md
# Multi-standard composite sync generator

This block produces an active-high composite sync waveform for broadcast-style video timing. It runs from a system clock with a pixel-rate clock enable: every enabled clock advances a horizontal count that spans 320 positions per line, and a line counter that steps at the end of each line. A three-bit system code picks the standard family, which sets the frame length (625 or 525 lines) and the lengths of the equalizing and serration sequences. A mode bit selects interlaced timing, or a non-interlaced frame that is one line shorter and in which both fields have identical timing.

Besides composite sync, the block drives a line-start strobe, a field-start strobe, a flag that marks the second field, and the raw horizontal count and line number. Downstream logic decodes its own pulses, such as blanking, drive and burst gates, against those counters. All outputs are registered and stay in step with each other.

Top module: `csync_gen`

## Requirements
- R1: The horizontal count runs 0 to LINE_CLKS-1 (default 320) and advances by one only on clocks with `pix_en` high. When `pix_en` is low, every output holds its value.
- R2: A synchronous reset sets the horizontal count to 0, the line number to 1, `field_two` to 0, and `csync`, `line_start` and `field_start` to 1.
- R3: On ordinary lines, `csync` is high for horizontal counts 0 to 23 and low for the rest of the line.
- R4: In equalizing half-lines, `csync` is high for the first 12 counts of each half-line (counts 0-11 or 160-171) and low for the rest of it.
- R5: In serration half-lines, `csync` is high for the first 136 counts of the half-line and low for its last 24 counts.
- R6: Each field opens with a pre-equalizing sequence, then a serration sequence, then a post-equalizing sequence, with lengths counted in half-lines. Codes 000, 001, 100, 101 and 111 give 5/5/5. Codes 010 and 110 give 6/6/6. Code 011 gives 6/7/6.
- R7: In interlaced mode (`progressive`=0) the frame has LINES_HI lines (625) for codes 000, 001, 100, 101 and 111, and LINES_LO lines (525) for the other codes. Field two begins at half-line index equal to the frame length, which is the middle of line 313 or 263. After the last line, counting wraps to line 1.
- R8: With `progressive`=1 the frame is one line shorter (624 or 524 lines). Field two begins at the start of line 313 or 263 and repeats the timing of field one.
- R9: `line_start` is high while the horizontal count is 0. `field_start` is high only during the first count of each field's first half-line. `field_two` is high from the start of field two to the end of the frame.
- R10: `sys_code` and `progressive` are taken only during reset and at the wrap to line 1. A change made mid-frame has no effect on the outputs until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate clock enable |
| sys_code | input | 3 | Standard selection code |
| progressive | input | 1 | 1 selects the non-interlaced, one-line-shorter frame |
| csync | output | 1 | Composite sync, active high |
| line_start | output | 1 | High at horizontal count 0 |
| field_start | output | 1 | High at the first count of each field |
| field_two | output | 1 | High during the second field |
| line_num | output | LINE_W | Current line number, starting at 1 |
| hcount | output | HCNT_W | Current horizontal count |

## Verification
The bench runs every standard family in both frame modes over frames shortened through the frame-length parameters. It compares each enabled clock against an independent tick-based model.

- **Field-two boundary:** a design that places it on the wrong half-line would start the second field's equalizing a half-line early or late, and would shift `field_two` by 160 counts.
- **PAL-M serration:** a design that ignores the seven-half-line serration of code 011 would end serration one half-line too soon.
- **Mid-frame change:** code and mode are changed in the middle of a frame. A design that applies them at once would change the frame length or the pulse shapes before line 1.
- **Stalled enable:** long runs with the enable low expose a counter or output register that moves without `pix_en`.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
  localparam int CNT_W = 12;  // wide enough for half-line indices
  localparam int SEQ_W = 5;   // half-line count of one vertical sequence

  typedef enum logic [1:0] {
    FAM_HI   = 2'd0,  // long-frame family
    FAM_LO_N = 2'd1,  // short frame, six-half-line serration
    FAM_LO_M = 2'd2   // short frame, seven-half-line serration
  } family_e;

  typedef enum logic [1:0] {
    SEG_EQ     = 2'd0,
    SEG_SERR   = 2'd1,
    SEG_NORMAL = 2'd2
  } seg_e;

  typedef struct packed {
    logic [CNT_W-1:0] lines;  // frame length; also field-two start in half-lines
    logic [SEQ_W-1:0] pre;
    logic [SEQ_W-1:0] ser;
    logic [SEQ_W-1:0] post;
  } cfg_t;

  function automatic family_e family_of(input logic [2:0] code);
    case (code)
      3'b010, 3'b110: family_of = FAM_LO_N;
      3'b011:         family_of = FAM_LO_M;
      default:        family_of = FAM_HI;
    endcase
  endfunction
endpackage

// File: rtl/csg_cfg_decode.sv
`timescale 1ns/1ps
module csg_cfg_decode
  import csg_pkg::*;
#(
  parameter int LINES_HI = 625,
  parameter int LINES_LO = 525,
  parameter int EQ_HI    = 5,
  parameter int EQ_LO    = 6,
  parameter int SER_HI   = 5,
  parameter int SER_LO_N = 6,
  parameter int SER_LO_M = 7
) (
  input  logic [2:0] sys_code,
  input  logic       progressive,
  output cfg_t       cfg
);
  logic [CNT_W-1:0] base_lines;

  always_comb begin
    case (family_of(sys_code))
      FAM_LO_N: begin
        base_lines = CNT_W'(LINES_LO);
        cfg.pre    = SEQ_W'(EQ_LO);
        cfg.ser    = SEQ_W'(SER_LO_N);
        cfg.post   = SEQ_W'(EQ_LO);
      end
      FAM_LO_M: begin
        base_lines = CNT_W'(LINES_LO);
        cfg.pre    = SEQ_W'(EQ_LO);
        cfg.ser    = SEQ_W'(SER_LO_M);
        cfg.post   = SEQ_W'(EQ_LO);
      end
      default: begin
        base_lines = CNT_W'(LINES_HI);
        cfg.pre    = SEQ_W'(EQ_HI);
        cfg.ser    = SEQ_W'(SER_HI);
        cfg.post   = SEQ_W'(EQ_HI);
      end
    endcase
    // the non-interlaced frame drops one line
    cfg.lines = base_lines - CNT_W'(progressive);
  end
endmodule

// File: rtl/csg_timebase.sv
`timescale 1ns/1ps
module csg_timebase
  import csg_pkg::*;
#(
  parameter int LINE_CLKS = 320,
  parameter int HCNT_W    = 9,
  parameter int LINE_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  cfg_t              cfg_in,
  output logic [HCNT_W-1:0] hcnt,
  output logic [LINE_W-1:0] line,
  output logic [HCNT_W-1:0] hcnt_nx,
  output logic [LINE_W-1:0] line_nx,
  output cfg_t              cfg_nx
);
  localparam logic [HCNT_W-1:0] LAST = HCNT_W'(LINE_CLKS - 1);

  cfg_t cfg;

  always_comb begin
    hcnt_nx = hcnt;
    line_nx = line;
    cfg_nx  = cfg;
    if (en) begin
      if (hcnt == LAST) begin
        hcnt_nx = '0;
        if (CNT_W'(line) >= cfg.lines) begin
          line_nx = LINE_W'(1);
          cfg_nx  = cfg_in;  // new settings only take hold at frame wrap
        end else begin
          line_nx = line + 1'b1;
        end
      end else begin
        hcnt_nx = hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      line <= LINE_W'(1);
      cfg  <= cfg_in;
    end else begin
      hcnt <= hcnt_nx;
      line <= line_nx;
      cfg  <= cfg_nx;
    end
  end
endmodule

// File: rtl/csg_pulse_decode.sv
`timescale 1ns/1ps
module csg_pulse_decode
  import csg_pkg::*;
#(
  parameter int LINE_CLKS = 320,
  parameter int HSYNC_W   = 24,
  parameter int EQ_W      = 12,
  parameter int SERR_GAP  = 24,
  parameter int HCNT_W    = 9,
  parameter int LINE_W    = 10
) (
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [LINE_W-1:0] line,
  input  cfg_t              cfg,
  output logic              csync,
  output logic              line_start,
  output logic              field_start,
  output logic              field_two
);
  localparam logic [HCNT_W-1:0] HALF_C = HCNT_W'(LINE_CLKS / 2);
  localparam logic [HCNT_W-1:0] EQ_C   = HCNT_W'(EQ_W);
  localparam logic [HCNT_W-1:0] SERR_C = HCNT_W'(LINE_CLKS / 2 - SERR_GAP);
  localparam logic [HCNT_W-1:0] HS_C   = HCNT_W'(HSYNC_W);

  logic              second;
  logic [HCNT_W-1:0] hpos;
  logic [LINE_W-1:0] lm1;
  logic [CNT_W-1:0]  hl, rel, b1, b2, b3;
  seg_e              seg;

  always_comb begin
    second = (hcnt >= HALF_C);
    hpos   = second ? (hcnt - HALF_C) : hcnt;
    lm1    = line - 1'b1;
    hl     = CNT_W'({lm1, second});             // half-line index in frame
    field_two = (hl >= cfg.lines);
    rel    = field_two ? (hl - cfg.lines) : hl; // half-line index in field
    b1 = CNT_W'(cfg.pre);
    b2 = b1 + CNT_W'(cfg.ser);
    b3 = b2 + CNT_W'(cfg.post);

    if (rel < b1)      seg = SEG_EQ;
    else if (rel < b2) seg = SEG_SERR;
    else if (rel < b3) seg = SEG_EQ;
    else               seg = SEG_NORMAL;

    case (seg)
      SEG_EQ:   csync = (hpos < EQ_C);
      SEG_SERR: csync = (hpos < SERR_C);
      default:  csync = (hcnt < HS_C);
    endcase

    line_start  = (hcnt == '0);
    field_start = (hpos == '0) && (rel == '0);
  end
endmodule

// File: rtl/csync_gen.sv
`timescale 1ns/1ps
module csync_gen
  import csg_pkg::*;
#(
  parameter int LINE_CLKS = 320,
  parameter int HSYNC_W   = 24,
  parameter int EQ_W      = 12,
  parameter int SERR_GAP  = 24,
  parameter int LINES_HI  = 625,
  parameter int LINES_LO  = 525,
  parameter int EQ_HI     = 5,
  parameter int EQ_LO     = 6,
  parameter int SER_HI    = 5,
  parameter int SER_LO_N  = 6,
  parameter int SER_LO_M  = 7,
  parameter int LINE_W    = 10,
  parameter int HCNT_W    = $clog2(LINE_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [2:0]        sys_code,
  input  logic              progressive,
  output logic              csync,
  output logic              line_start,
  output logic              field_start,
  output logic              field_two,
  output logic [LINE_W-1:0] line_num,
  output logic [HCNT_W-1:0] hcount
);
  cfg_t              cfg_in, cfg_nx;
  logic [HCNT_W-1:0] hcnt_nx;
  logic [LINE_W-1:0] line_nx;
  logic              cs_d, ls_d, fs_d, f2_d;

  csg_cfg_decode #(
    .LINES_HI(LINES_HI), .LINES_LO(LINES_LO), .EQ_HI(EQ_HI), .EQ_LO(EQ_LO),
    .SER_HI(SER_HI), .SER_LO_N(SER_LO_N), .SER_LO_M(SER_LO_M)
  ) u_cfg (
    .sys_code(sys_code), .progressive(progressive), .cfg(cfg_in)
  );

  csg_timebase #(
    .LINE_CLKS(LINE_CLKS), .HCNT_W(HCNT_W), .LINE_W(LINE_W)
  ) u_tb (
    .clk(clk), .rst(rst), .en(pix_en), .cfg_in(cfg_in),
    .hcnt(hcount), .line(line_num),
    .hcnt_nx(hcnt_nx), .line_nx(line_nx), .cfg_nx(cfg_nx)
  );

  // decode the upcoming state so the registered outputs line up with the counters
  csg_pulse_decode #(
    .LINE_CLKS(LINE_CLKS), .HSYNC_W(HSYNC_W), .EQ_W(EQ_W),
    .SERR_GAP(SERR_GAP), .HCNT_W(HCNT_W), .LINE_W(LINE_W)
  ) u_dec (
    .hcnt(hcnt_nx), .line(line_nx), .cfg(cfg_nx),
    .csync(cs_d), .line_start(ls_d), .field_start(fs_d), .field_two(f2_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csync       <= 1'b1;  // line 1 opens with an equalizing pulse
      line_start  <= 1'b1;
      field_start <= 1'b1;
      field_two   <= 1'b0;
    end else if (pix_en) begin
      csync       <= cs_d;
      line_start  <= ls_d;
      field_start <= fs_d;
      field_two   <= f2_d;
    end
  end
endmodule

// File: rtl/csync_gen_chk.sv
`timescale 1ns/1ps
module csync_gen_chk #(
  parameter int LINE_CLKS = 320,
  parameter int LINES_MAX = 625,
  parameter int LINE_W    = 10,
  parameter int HCNT_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic              csync,
  input logic              line_start,
  input logic              field_start,
  input logic              field_two,
  input logic [LINE_W-1:0] line_num,
  input logic [HCNT_W-1:0] hcount
);
  localparam logic [HCNT_W-1:0] LAST = HCNT_W'(LINE_CLKS - 1);
  localparam logic [HCNT_W-1:0] MID  = HCNT_W'(LINE_CLKS / 2);
  localparam logic [LINE_W-1:0] LMAX = LINE_W'(LINES_MAX);

  AST_HCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    hcount <= LAST); // R1
  AST_HCOUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcount == LAST) |=> (hcount == '0)); // R1
  AST_HCOUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcount != LAST) |=> (hcount == HCNT_W'($past(hcount) + 1'b1))); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(hcount) && $stable(line_num) && $stable(csync) && $stable(field_two))); // R1
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (line_num != '0) && (line_num <= LMAX)); // R7
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcount == LAST) |=>
      ((line_num == LINE_W'($past(line_num) + 1'b1)) || (line_num == LINE_W'(1)))); // R7
  AST_FIELD_ONE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (line_num == LINE_W'(1)) |-> !field_two); // R7
  AST_LINE_STROBE: assert property (@(posedge clk) disable iff (rst)
    line_start == (hcount == '0)); // R9
  AST_FIELD_PHASE: assert property (@(posedge clk) disable iff (rst)
    field_start |-> (hcount == '0 || hcount == MID)); // R9
  AST_PULSE_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    line_start |-> csync); // R3
endmodule

bind csync_gen csync_gen_chk #(
  .LINE_CLKS(LINE_CLKS), .LINES_MAX(LINES_HI), .LINE_W(LINE_W), .HCNT_W(HCNT_W)
) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .csync(csync),
  .line_start(line_start), .field_start(field_start), .field_two(field_two),
  .line_num(line_num), .hcount(hcount)
);

// File: tb/csync_gen_test.sv
`timescale 1ns/1ps
module csync_gen_test;
  localparam int LC = 320;
  localparam int LA = 41;  // shortened long-family frame
  localparam int LB = 33;  // shortened short-family frame

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic [2:0] sys_code = 3'b101;
  logic       progressive = 1'b0;
  logic       csync, line_start, field_start, field_two;
  logic [9:0] line_num;
  logic [8:0] hcount;

  csync_gen #(.LINES_HI(LA), .LINES_LO(LB)) uut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .sys_code(sys_code),
    .progressive(progressive), .csync(csync), .line_start(line_start),
    .field_start(field_start), .field_two(field_two),
    .line_num(line_num), .hcount(hcount)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    hc;
    int    ln;
    bit    cs;
    bit    ls;
    bit    fs;
    bit    f2;
    string tag_cs;
    string tag_ln;
    string ctx;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  int t = 0;
  int m_lines, m_pre, m_ser, m_post;
  bit m_prog;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  function automatic void latch_cfg();
    case (sys_code)
      3'b010, 3'b110: begin m_lines = LB; m_pre = 6; m_ser = 6; m_post = 6; end
      3'b011:         begin m_lines = LB; m_pre = 6; m_ser = 7; m_post = 6; end
      default:        begin m_lines = LA; m_pre = 5; m_ser = 5; m_post = 5; end
    endcase
    if (progressive) m_lines = m_lines - 1;
    m_prog = progressive;
  endfunction

  function automatic exp_t model(input int tt);
    exp_t x;
    int h, half, rel, hp;
    bit in2;
    h    = tt % LC;
    half = tt / (LC / 2);
    hp   = h % (LC / 2);
    in2  = (half >= m_lines);
    rel  = in2 ? half - m_lines : half;
    x.hc = h;
    x.ln = tt / LC + 1;
    x.ls = (h == 0);
    x.fs = (hp == 0) && (rel == 0);
    x.f2 = in2;
    x.tag_ln = m_prog ? "R8" : "R7";
    if (rel < m_pre || (rel >= m_pre + m_ser && rel < m_pre + m_ser + m_post)) begin
      x.cs = (hp < 12); x.tag_cs = "R4 R6";
    end else if (rel < m_pre + m_ser) begin
      x.cs = (hp < 136); x.tag_cs = "R5 R6";
    end else begin
      x.cs = (h < 24); x.tag_cs = "R3";
    end
    x.ctx = "";
    return x;
  endfunction

  // driver: one clock of stimulus plus the expected state after that edge
  task automatic step(input bit e, input string ctx);
    exp_t x;
    @(negedge clk);
    pix_en = e;
    if (e) begin
      t++;
      if (t == m_lines * LC) begin
        t = 0;
        latch_cfg();
      end
    end
    x = model(t);
    x.ctx = ctx;
    q.push_back(x);
  endtask

  task automatic run(input int n, input string ctx);
    for (int i = 0; i < n; i++) step(1'b1, ctx);
  endtask

  task automatic do_reset(input logic [2:0] code, input logic prog);
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b0; sys_code = code; progressive = prog;
    repeat (2) @(negedge clk);
    chk(hcount == 9'd0,     "R2", "hcount",      hcount, 0);
    chk(line_num == 10'd1,  "R2", "line_num",    line_num, 1);
    chk(csync == 1'b1,      "R2", "csync",       csync, 1);
    chk(line_start == 1'b1, "R2", "line_start",  line_start, 1);
    chk(field_start == 1'b1,"R2", "field_start", field_start, 1);
    chk(field_two == 1'b0,  "R2", "field_two",   field_two, 0);
    latch_cfg();
    t = 0;
    rst = 1'b0;
  endtask

  // monitor: compare after each edge against the oldest expected item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(hcount == x.hc,      {x.ctx, " R1"},     "hcount",      hcount, x.hc);
        chk(line_num == x.ln,    {x.ctx, " ", x.tag_ln}, "line_num", line_num, x.ln);
        chk(csync == x.cs,       {x.ctx, " ", x.tag_cs}, "csync",    csync, x.cs);
        chk(line_start == x.ls,  {x.ctx, " R9"},     "line_start",  line_start, x.ls);
        chk(field_start == x.fs, {x.ctx, " R9"},     "field_start", field_start, x.fs);
        chk(field_two == x.f2,   {x.ctx, " ", x.tag_ln}, "field_two", field_two, x.f2);
      end
    end
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2 reset, then long-family interlaced frame and wrap (R7)
    do_reset(3'b101, 1'b0);
    run(LA * LC + 2 * LC, "");
    // short family, six-half-line serration (R6, R7)
    do_reset(3'b010, 1'b0);
    run(LB * LC + 2 * LC, "");
    // short family, seven-half-line serration (R6)
    do_reset(3'b011, 1'b0);
    run(LB * LC + 2 * LC, "");
    // non-interlaced variants (R8)
    do_reset(3'b000, 1'b1);
    run((LA - 1) * LC + 2 * LC, "");
    do_reset(3'b110, 1'b1);
    run((LB - 1) * LC + 2 * LC, "");
    // code 111 behaves as the long family (R6), then stalled enable (R1)
    do_reset(3'b111, 1'b0);
    run(10 * LC, "");
    for (int i = 0; i < 1500; i++) step((i % 3) != 2, "R1");
    for (int i = 0; i < 40; i++) step(1'b0, "R1");
    // mid-frame change of code and mode waits for the wrap (R10)
    do_reset(3'b010, 1'b0);
    run(5 * LC, "R10");
    sys_code = 3'b101;
    progressive = 1'b1;
    run((LB - 5) * LC + (LA + 1) * LC, "R10");
    @(negedge clk);
    pix_en = 1'b0;
    @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule